// File: doc/BRIEF.md
# Board Interrupt Pin Monitor and Override

This block sits between a set of board-level interrupt sources and the interrupt pins that go to a processor. Software reaches it through a simple strobed register port. Through that port it can read the live electrical level of every pin. On a chosen subset of lines it can pick level or edge drive and the active polarity. On any line it can force the pin high or low whatever the source is doing, which lets the force act as a mask.

Each line belongs to one of three kinds. A direct line takes its own source input. A gated line is built from one shared fault signal that is qualified by that line's module-absent input: the fault reaches the pin only while the module is present (absent input low). A line with no source sits at its idle level unless it is forced. Every source passes through a two-flop synchronizer. Lines with drive-mode control then pass through a shaper that gives either a level or a single-cycle edge pulse with a selectable polarity. Lines without control pass the synchronized level through unchanged. In the default build the lines are: 0 direct with control, 1 no source, 2 direct, 3 and 4 gated with control, 5 direct, 6 direct.

Top module: `irq_pin_override`

## Requirements
- R1: After reset every control field reads 0 (level, active-low) and every drive field reads 0 (follow). With all inputs low the pins are 7'b0011011.
- R2: A read strobe at address 0 returns, on the next clock, the pin levels as they stood when the strobe was sampled, in bits [6:0]. No polarity interpretation is applied and the upper bits are 0.
- R3: In level mode a controlled line's pin is the inverted synchronized source when active-low (control bit 2i+1 = 0) and the source itself when active-high (bit 2i+1 = 1). A source change appears on the pin after two clock edges.
- R4: In edge mode (control bit 2i = 1), a rising edge of the synchronized source asserts the pin for exactly one clock: high when active-high, low when active-low. Falling edges and steady levels leave the pin at the inactive level.
- R5: Control fields exist only for lines 0, 3 and 4 (bits [1:0], [7:6], [9:8] at address 1). The other control bits read 0, and writes to them have no effect.
- R6: A drive field (bits [2i+1:2i] at address 2) of 01 forces the pin low and 10 forces it high, whatever the source is. The force shows on the pin right after the clock edge that samples the write.
- R7: Drive codes 00 and 11 make the pin follow its shaped source.
- R8: Gated lines 3 and 4 take as source the shared fault AND NOT their own module-absent input (mod_absent[3], mod_absent[4]). Direct lines take src_in at their own index.
- R9: Line 1 has no source. It stays high and ignores src_in[1] unless its drive field forces it.
- R10: Lines without control (2, 5, 6) pass the synchronized source level uninverted, two clock edges after it changes.
- R11: Address 3 reads 0. Writes to addresses 0 and 3 change neither the control nor the drive fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_LINES | Per-line source for direct lines |
| fault_in | input | 1 | Shared fault feeding the gated lines |
| mod_absent | input | NUM_LINES | Per-line module-absent qualifier for gated lines |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address: 0 status, 1 control, 2 drive |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid on the clock after rd_en |
| irq_out | output | NUM_LINES | Interrupt pin levels to the processor |

## Verification
The bench builds the block with its default parameters: seven lines, 16-bit data, a 2-bit address, two synchronizer stages, control on lines 0, 3 and 4, gating on lines 3 and 4, and line 1 without a source. With these values every line kind and every mix of control and no control can be reached. The full address space, including the one unmapped address, is reachable too. Each shaper variant can be driven through both polarities and both drive modes.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

   typedef enum logic [1:0] {
      DRV_FOLLOW     = 2'b00,
      DRV_FORCE_LO   = 2'b01,
      DRV_FORCE_HI   = 2'b10,
      DRV_FOLLOW_ALT = 2'b11
   } drv_code_e;

   localparam int unsigned REG_STATUS = 0;
   localparam int unsigned REG_CTRL   = 1;
   localparam int unsigned REG_DRIVE  = 2;
   localparam int unsigned MAX_LINES  = 32;

   // widen a per-line mask into a per-field (two bits per line) mask
   function automatic logic [2*MAX_LINES-1:0] pair_mask(input logic [MAX_LINES-1:0] line_mask,
                                                         input int unsigned n);
      logic [2*MAX_LINES-1:0] r;
      r = '0;
      for (int i = 0; i < MAX_LINES; i++) begin
         if (i < int'(n)) r[2*i +: 2] = {2{line_mask[i]}};
      end
      return r;
   endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper
   import irq_pin_pkg::*;
#(
   parameter bit          HAS_SRC     = 1'b1,
   parameter bit          HAS_CTL     = 1'b0,
   parameter bit          IDLE_LEVEL  = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw,
   input  logic       edge_mode,
   input  logic       act_high,
   input  logic [1:0] drive,
   output logic       pin
);
   logic src_lvl;

   generate
      if (HAS_SRC) begin : g_src
         logic sync_q;

         irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw),
            .q     (sync_q)
         );

         if (HAS_CTL) begin : g_ctl
            logic sync_d;
            logic rise;
            logic asserted;

            always_ff @(posedge clk) begin
               if (!rst_n) sync_d <= 1'b0;
               else        sync_d <= sync_q;
            end

            assign rise     = sync_q & ~sync_d;
            assign asserted = edge_mode ? rise : sync_q;
            assign src_lvl  = act_high ? asserted : ~asserted;
         end else begin : g_pass
            logic unused_ctl;
            assign unused_ctl = ^{edge_mode, act_high};
            assign src_lvl    = sync_q;
         end
      end else begin : g_nosrc
         logic unused_in;
         assign unused_in = ^{clk, rst_n, raw, edge_mode, act_high};
         assign src_lvl   = IDLE_LEVEL;
      end
   endgenerate

   always_comb begin
      unique case (drv_code_e'(drive))
         DRV_FORCE_LO: pin = 1'b0;
         DRV_FORCE_HI: pin = 1'b1;
         default:      pin = src_lvl;
      endcase
   end
endmodule

// File: rtl/irq_pin_regs.sv
module irq_pin_regs
   import irq_pin_pkg::*;
#(
   parameter int unsigned            NUM_LINES = 7,
   parameter int unsigned            DATA_W    = 16,
   parameter int unsigned            ADDR_W    = 2,
   parameter logic [NUM_LINES-1:0]   CTL_MASK  = '1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [NUM_LINES-1:0]   pin_lvl,
   output logic [2*NUM_LINES-1:0] ctl_q,
   output logic [2*NUM_LINES-1:0] drv_q,
   output logic [DATA_W-1:0]      rd_data
);
   localparam int unsigned FIELD_W = 2 * NUM_LINES;

   logic hit_status, hit_ctrl, hit_drive;
   logic wr_ctrl, wr_drive;
   logic unused_wr;

   assign hit_status = (addr == ADDR_W'(REG_STATUS));
   assign hit_ctrl   = (addr == ADDR_W'(REG_CTRL));
   assign hit_drive  = (addr == ADDR_W'(REG_DRIVE));
   assign wr_ctrl    = wr_en & hit_ctrl;
   assign wr_drive   = wr_en & hit_drive;
   assign unused_wr  = ^wr_data;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         logic [1:0] drv_r;

         always_ff @(posedge clk) begin
            if (!rst_n)        drv_r <= DRV_FOLLOW;
            else if (wr_drive) drv_r <= wr_data[2*i +: 2];
         end
         assign drv_q[2*i +: 2] = drv_r;

         if (CTL_MASK[i]) begin : g_ctl
            logic [1:0] ctl_r;
            always_ff @(posedge clk) begin
               if (!rst_n)       ctl_r <= 2'b00;
               else if (wr_ctrl) ctl_r <= wr_data[2*i +: 2];
            end
            assign ctl_q[2*i +: 2] = ctl_r;
         end else begin : g_noctl
            assign ctl_q[2*i +: 2] = 2'b00;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         if (hit_status)     rd_data <= DATA_W'(pin_lvl);
         else if (hit_ctrl)  rd_data <= DATA_W'(ctl_q[FIELD_W-1:0]);
         else if (hit_drive) rd_data <= DATA_W'(drv_q[FIELD_W-1:0]);
         else                rd_data <= '0;
      end
   end
endmodule

// File: rtl/irq_pin_override.sv
module irq_pin_override
   import irq_pin_pkg::*;
#(
   parameter int unsigned          NUM_LINES   = 7,
   parameter int unsigned          DATA_W      = 16,
   parameter int unsigned          ADDR_W      = 2,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter logic [NUM_LINES-1:0] CTL_MASK    = 7'b0011001,
   parameter logic [NUM_LINES-1:0] GATE_MASK   = 7'b0011000,
   parameter logic [NUM_LINES-1:0] NOSRC_MASK  = 7'b0000010,
   parameter bit                   IDLE_LEVEL  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] src_in,
   input  logic                 fault_in,
   input  logic [NUM_LINES-1:0] mod_absent,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   output logic [NUM_LINES-1:0] irq_out
);
   localparam int unsigned FIELD_W = 2 * NUM_LINES;

   generate
      if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
         $error("irq_pin_override: NUM_LINES out of range");
      end
      if (DATA_W < FIELD_W) begin : g_bad_width
         $error("irq_pin_override: DATA_W too small for two bits per line");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("irq_pin_override: ADDR_W must reach three registers");
      end
      if ((GATE_MASK & NOSRC_MASK) != '0) begin : g_bad_masks
         $error("irq_pin_override: a line cannot be gated and sourceless");
      end
   endgenerate

   logic [FIELD_W-1:0]   ctl_q;
   logic [FIELD_W-1:0]   drv_q;
   logic [NUM_LINES-1:0] raw;

   irq_pin_regs #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CTL_MASK  (CTL_MASK)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wr_data (wr_data),
      .pin_lvl (irq_out),
      .ctl_q   (ctl_q),
      .drv_q   (drv_q),
      .rd_data (rd_data)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         if (NOSRC_MASK[i]) begin : g_nosrc
            logic unused_in;
            assign unused_in = src_in[i] ^ mod_absent[i];
            assign raw[i]    = 1'b0;
         end else if (GATE_MASK[i]) begin : g_gated
            logic unused_src;
            assign unused_src = src_in[i];
            assign raw[i]     = fault_in & ~mod_absent[i];
         end else begin : g_direct
            logic unused_abs;
            assign unused_abs = mod_absent[i];
            assign raw[i]     = src_in[i];
         end

         irq_pin_shaper #(
            .HAS_SRC     (!NOSRC_MASK[i]),
            .HAS_CTL     (CTL_MASK[i]),
            .IDLE_LEVEL  (IDLE_LEVEL),
            .SYNC_STAGES (SYNC_STAGES)
         ) u_shaper (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (raw[i]),
            .edge_mode (ctl_q[2*i]),
            .act_high  (ctl_q[2*i+1]),
            .drive     (drv_q[2*i +: 2]),
            .pin       (irq_out[i])
         );
      end
   endgenerate
endmodule

// File: rtl/irq_pin_override_chk.sv
module irq_pin_override_chk
   import irq_pin_pkg::*;
#(
   parameter int unsigned          NUM_LINES = 7,
   parameter int unsigned          DATA_W    = 16,
   parameter int unsigned          ADDR_W    = 2,
   parameter logic [NUM_LINES-1:0] CTL_MASK  = 7'b0011001
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wr_data,
   input logic [DATA_W-1:0]    rd_data,
   input logic [NUM_LINES-1:0] irq_out
);
   localparam logic [2*MAX_LINES-1:0] PAIRS    = pair_mask(MAX_LINES'(CTL_MASK), NUM_LINES);
   localparam logic [DATA_W-1:0]      CTL_KEEP = DATA_W'(PAIRS);

   // R2: status read returns the pin levels seen at the strobe
   p_status_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(REG_STATUS)) |=> (rd_data == DATA_W'($past(irq_out))));

   // R5: control bits of lines without control read as zero
   p_ctl_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(REG_CTRL)) |=> ((rd_data & ~CTL_KEEP) == '0));

   // R11: unmapped address reads zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(3)) |=> (rd_data == '0));

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         // R6: force-low write drives the pin low after the write edge
         p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(REG_DRIVE) && wr_data[2*i +: 2] == 2'b01) |=> !irq_out[i]);
         // R6: force-high write drives the pin high after the write edge
         p_force_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(REG_DRIVE) && wr_data[2*i +: 2] == 2'b10) |=> irq_out[i]);
      end
   endgenerate
endmodule

bind irq_pin_override irq_pin_override_chk #(
   .NUM_LINES (NUM_LINES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .CTL_MASK  (CTL_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .irq_out (irq_out)
);

// File: tb/irq_pin_override_tb.sv
`timescale 1ns/1ps
module irq_pin_override_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  src_in;
   logic        fault_in;
   logic [6:0]  mod_absent;
   logic        wr_en, rd_en;
   logic [1:0]  addr;
   logic [15:0] wr_data;
   logic [15:0] rd_data;
   logic [6:0]  irq_out;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   irq_pin_override dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_in     (src_in),
      .fault_in   (fault_in),
      .mod_absent (mod_absent),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .irq_out    (irq_out)
   );

   typedef struct packed {
      logic [6:0] src;
      logic       fault;
      logic [6:0] absent;
      logic [6:0] exp;
   } vec_t;

   // default config: controlled lines level/active-low, all drives follow
   localparam vec_t VECS [7] = '{
      '{7'b0000000, 1'b0, 7'b0000000, 7'b0011011},
      '{7'b1111111, 1'b0, 7'b0000000, 7'b1111110},
      '{7'b0000000, 1'b1, 7'b0000000, 7'b0000011},
      '{7'b0000000, 1'b1, 7'b0001000, 7'b0001011},
      '{7'b0000000, 1'b1, 7'b0010000, 7'b0010011},
      '{7'b0100100, 1'b1, 7'b0011000, 7'b0111111},
      '{7'b1000001, 1'b0, 7'b0000000, 7'b1011010}
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      src_in = '0; fault_in = 1'b0; mod_absent = '0;
      wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
      do_reset();

      // R1 reset state
      check("R1 pins after reset", 16'(irq_out), 16'h001B);
      reg_rd(2'd1, d); check("R1 control reset", d, 16'h0000);
      reg_rd(2'd2, d); check("R1 drive reset", d, 16'h0000);

      // R3 R8 R9 R10 R2: vector table under default config
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         src_in = VECS[k].src; fault_in = VECS[k].fault; mod_absent = VECS[k].absent;
         settle();
         check($sformatf("R3/R8/R9/R10 vector %0d pins", k), 16'(irq_out), 16'(VECS[k].exp));
         reg_rd(2'd0, d);
         check($sformatf("R2 vector %0d status", k), d, 16'(VECS[k].exp));
      end

      // R10 latency: line 2 follows uninverted after two edges
      @(negedge clk); src_in = '0; fault_in = 1'b0; mod_absent = '0;
      settle();
      @(negedge clk); src_in[2] = 1'b1;
      @(negedge clk); check("R10 one edge no change", 16'(irq_out[2]), 16'h0);
      @(negedge clk); check("R10 two edges change", 16'(irq_out[2]), 16'h1);

      // R3 active-high level on line 0, latency
      reg_wr(2'd1, 16'h0002);
      src_in = '0; settle();
      check("R3 active-high idle", 16'(irq_out[0]), 16'h0);
      src_in[0] = 1'b1;
      @(negedge clk); check("R3 one edge no change", 16'(irq_out[0]), 16'h0);
      @(negedge clk); check("R3 active-high asserted", 16'(irq_out[0]), 16'h1);

      // R4 edge active-high on line 0
      src_in[0] = 1'b0;
      reg_wr(2'd1, 16'h0003);
      settle();
      check("R4 edge idle", 16'(irq_out[0]), 16'h0);
      src_in[0] = 1'b1;
      @(negedge clk); check("R4 before pulse", 16'(irq_out[0]), 16'h0);
      @(negedge clk); check("R4 pulse high", 16'(irq_out[0]), 16'h1);
      @(negedge clk); check("R4 pulse one cycle", 16'(irq_out[0]), 16'h0);
      @(negedge clk); check("R4 steady high no pulse", 16'(irq_out[0]), 16'h0);
      src_in[0] = 1'b0;
      settle();
      check("R4 falling edge no pulse", 16'(irq_out[0]), 16'h0);

      // R4 R8 edge active-low on gated line 3
      reg_wr(2'd1, 16'h0040);
      fault_in = 1'b0; mod_absent = '0; settle();
      check("R4 active-low edge idle", 16'(irq_out[3]), 16'h1);
      fault_in = 1'b1;
      @(negedge clk); check("R4 gated before pulse", 16'(irq_out[3]), 16'h1);
      @(negedge clk); check("R4 gated pulse low", 16'(irq_out[3]), 16'h0);
      @(negedge clk); check("R4 gated pulse ends", 16'(irq_out[3]), 16'h1);
      fault_in = 1'b0; mod_absent[3] = 1'b1; settle();
      fault_in = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk); check("R8 absent module blocks fault", 16'(irq_out[3]), 16'h1);
      end
      fault_in = 1'b0; mod_absent = '0;

      // R5 control only on lines 0, 3, 4
      reg_wr(2'd1, 16'hFFFF);
      reg_rd(2'd1, d); check("R5 control readback", d, 16'h03C3);
      src_in = 7'b0100100; settle();
      check("R5 line 2 unaffected", 16'(irq_out[2]), 16'h1);
      check("R5 line 5 unaffected", 16'(irq_out[5]), 16'h1);
      src_in = '0; settle();
      check("R5 line 2 follows low", 16'(irq_out[2]), 16'h0);

      // R6 force
      reg_wr(2'd1, 16'h0000);
      settle();
      check("R6 baseline pins", 16'(irq_out), 16'h001B);
      reg_wr(2'd2, 16'h0024);
      check("R6 force low line1 high line2", 16'(irq_out), 16'h001D);
      reg_rd(2'd2, d); check("R6 drive readback", d, 16'h0024);
      reg_rd(2'd0, d); check("R2 status shows forced pins", d, 16'h001D);
      src_in[2] = 1'b1; settle();
      src_in[2] = 1'b0; settle();
      check("R6 forced high ignores source", 16'(irq_out[2]), 16'h1);
      reg_wr(2'd2, 16'h0001);
      check("R6 mask line0 low", 16'(irq_out[0]), 16'h0);

      // R7 follow codes
      reg_wr(2'd2, 16'h0030);
      src_in[2] = 1'b1; settle();
      check("R7 code 11 follows high", 16'(irq_out[2]), 16'h1);
      src_in[2] = 1'b0; settle();
      check("R7 code 11 follows low", 16'(irq_out[2]), 16'h0);
      check("R7 code 00 line0 follows", 16'(irq_out[0]), 16'h1);

      // R9 sourceless line
      src_in[1] = 1'b1; settle();
      check("R9 line1 ignores source", 16'(irq_out[1]), 16'h1);
      src_in[1] = 1'b0;

      // R11 unmapped and status writes
      reg_wr(2'd1, 16'h0041);
      reg_wr(2'd3, 16'hFFFF);
      reg_wr(2'd0, 16'hFFFF);
      reg_rd(2'd1, d); check("R11 control untouched", d, 16'h0041);
      reg_rd(2'd2, d); check("R11 drive untouched", d, 16'h0030);
      reg_rd(2'd3, d); check("R11 unmapped reads zero", d, 16'h0000);

      // R1 reset again clears fields
      do_reset();
      reg_rd(2'd1, d); check("R1 control cleared", d, 16'h0000);
      reg_rd(2'd2, d); check("R1 drive cleared", d, 16'h0000);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule